// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is an APB slave that holds a bank of independent down-counting timer channels. Software writes a start value to a channel, chooses how the counter refills itself after it reaches zero, and enables it. When a counter expires, the channel latches a pending flag. That flag drives the channel's own interrupt line unless the channel's mask bit is set. An OR of all unmasked channel lines gives one combined interrupt output.

Pending flags are cleared by reads, not by writes. A read of a channel's acknowledge register clears only that channel. A read of the shared acknowledge register clears every channel. Shared status words collect the raw and the masked pending flags of all channels, so one read finds the source. Software that wants a rising time base inverts the current count.

The slave never inserts wait states. Reads return combinationally during the access phase.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every channel is disabled. All load, count and control fields read 0, all interrupt lines are low, and address 0xAC reads the `VERSION` parameter.
- R2: Channel n occupies a 0x14-byte slot at n*0x14. Within a slot, offset 0x00 is the load value (read/write), 0x04 the current count (read-only), 0x08 control, 0x0C the acknowledge register and 0x10 the masked status bit. Reads of any other address, including slots at or above `NUM_CH`, return 0. Writes to such addresses change nothing. `pready` is always 1.
- R3: Control bit 0 is enable, bit 1 selects refill-from-load (1) or refill-all-ones (0), and bit 2 masks the interrupt (1 = masked). All three bits read back as written.
- R4: A control write that turns enable from 0 to 1 copies the load value into the counter on that clock edge. Each following clock decrements the counter by one while it is nonzero.
- R5: In refill-from-load mode, a channel at count 0 reloads the load value on the next edge and sets its pending flag, so the interval between expiries is load+1 clocks.
- R6: In refill-all-ones mode, a channel at count 0 reloads 0xFFFFFFFF on the next edge and sets its pending flag.
- R7: A pending flag stays set until it is cleared. A read of a channel's 0x0C register returns 0 and clears that channel's flag only.
- R8: A read of 0xA4 returns 0 and clears the pending flags of all channels.
- R9: With the mask bit set, the channel keeps counting and its raw flag still sets. Its interrupt line, its bit at 0xA0 and its 0x10 status all stay 0.
- R10: A control write with enable 0 freezes the counter at its current value and clears the channel's pending flag.
- R11: If an expiry and a clearing read of the same channel fall on the same edge, the flag ends set.
- R12: 0xA0 reads the masked flags and 0xA8 the raw flags, with bit n for channel n. `anyIrq` is the OR of all channel lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock for bus and counters |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high |
| chanIrq | output | NUM_CH | Per-channel interrupt lines |
| anyIrq | output | 1 | OR of all channel lines |

## Verification
The assertions assume that bus transfers follow the setup-then-access order. They also assume that a write to a load register and a control write never target one channel in the same cycle, which the single-transfer bus guarantees. The bench drives every transfer through one write task and one read task, each holding select for exactly one setup cycle and one access cycle. It writes load values only to disabled channels. Edge-sensitive cases, such as an acknowledge read that coincides with an expiry, are reached by counting clock edges from an observed interrupt rise, not by polling.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int REG_STRIDE = 20;

  localparam logic [4:0] OFS_LOAD  = 5'd0;
  localparam logic [4:0] OFS_VALUE = 5'd4;
  localparam logic [4:0] OFS_CTRL  = 5'd8;
  localparam logic [4:0] OFS_ACK   = 5'd12;
  localparam logic [4:0] OFS_STAT  = 5'd16;

  localparam logic [ADDR_W-1:0] GA_MASKED = 8'hA0;
  localparam logic [ADDR_W-1:0] GA_ACK    = 8'hA4;
  localparam logic [ADDR_W-1:0] GA_RAW    = 8'hA8;
  localparam logic [ADDR_W-1:0] GA_VER    = 8'hAC;

  // per-channel strobes from the bus decoder to the counter datapath
  typedef struct packed {
    logic wrLoad;
    logic wrCtrl;
    logic clrIrq;
  } chanStrobe_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'h3231_312A
) (
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] loadVec,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cntVec,
  input  logic [NUM_CH-1:0][2:0]       ctrlVec,
  input  logic [NUM_CH-1:0]            rawVec,
  input  logic [NUM_CH-1:0]            maskedVec,
  output chanStrobe_t [NUM_CH-1:0]     strobe,
  output logic [DATA_W-1:0]            prdata
);
  logic accWr, accRd, globalAck;

  assign accWr     = psel & penable & pwrite;
  assign accRd     = psel & penable & ~pwrite;
  assign globalAck = accRd && (paddr == GA_ACK);

  always_comb begin
    logic [4:0] ofs;
    strobe = '0;
    prdata = '0;
    ofs    = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(paddr) >= i * REG_STRIDE && int'(paddr) < (i + 1) * REG_STRIDE) begin
        ofs = 5'(int'(paddr) - i * REG_STRIDE);
        case (ofs)
          OFS_LOAD: begin
            prdata = DATA_W'(loadVec[i]);
            strobe[i].wrLoad = accWr;
          end
          OFS_VALUE: prdata = DATA_W'(cntVec[i]);
          OFS_CTRL: begin
            prdata = DATA_W'(ctrlVec[i]);
            strobe[i].wrCtrl = accWr;
          end
          OFS_ACK:  strobe[i].clrIrq = accRd;
          OFS_STAT: prdata = DATA_W'(maskedVec[i]);
          default: ;
        endcase
      end
      if (globalAck) strobe[i].clrIrq = 1'b1;
    end
    case (paddr)
      GA_MASKED: prdata = DATA_W'(maskedVec);
      GA_RAW:    prdata = DATA_W'(rawVec);
      GA_VER:    prdata = VERSION;
      default: ;
    endcase
  end
endmodule

// File: rtl/tick_timer_datapath.sv
module tick_timer_datapath
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 32
) (
  input  logic                         clk,
  input  logic                         rstn,
  input  chanStrobe_t [NUM_CH-1:0]     strobe,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NUM_CH-1:0][CNT_W-1:0] loadVec,
  output logic [NUM_CH-1:0][CNT_W-1:0] cntVec,
  output logic [NUM_CH-1:0][2:0]       ctrlVec,
  output logic [NUM_CH-1:0]            rawVec,
  output logic [NUM_CH-1:0]            expVec,
  output logic [NUM_CH-1:0]            maskedVec
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [CNT_W-1:0] loadQ, cntQ;
    logic enQ, perQ, maskQ, rawQ;
    logic startNow, stopNow, expire;

    assign startNow = strobe[g].wrCtrl & wdata[0] & ~enQ;
    assign stopNow  = strobe[g].wrCtrl & ~wdata[0];
    assign expire   = enQ & ~stopNow & (cntQ == '0);

    always_ff @(posedge clk or negedge rstn) begin
      if (!rstn) begin
        loadQ <= '0;
        cntQ  <= '0;
        enQ   <= 1'b0;
        perQ  <= 1'b0;
        maskQ <= 1'b0;
        rawQ  <= 1'b0;
      end else begin
        if (strobe[g].wrLoad) loadQ <= wdata[CNT_W-1:0];
        if (strobe[g].wrCtrl) {maskQ, perQ, enQ} <= wdata[2:0];

        if (startNow)
          cntQ <= loadQ;
        else if (enQ && !stopNow)
          cntQ <= expire ? (perQ ? loadQ : '1) : cntQ - 1'b1;

        // disable first, then a fresh expiry beats a clearing read
        if (stopNow)              rawQ <= 1'b0;
        else if (expire)          rawQ <= 1'b1;
        else if (strobe[g].clrIrq) rawQ <= 1'b0;
      end
    end

    assign loadVec[g]   = loadQ;
    assign cntVec[g]    = cntQ;
    assign ctrlVec[g]   = {maskQ, perQ, enQ};
    assign rawVec[g]    = rawQ;
    assign expVec[g]    = expire;
    assign maskedVec[g] = rawQ & ~maskQ;
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 32,
  parameter logic [31:0] VERSION = 32'h3231_312A
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [7:0]        paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic [NUM_CH-1:0] chanIrq,
  output logic              anyIrq
);
  chanStrobe_t [NUM_CH-1:0]     strobe;
  logic [NUM_CH-1:0][CNT_W-1:0] loadVec, cntVec;
  logic [NUM_CH-1:0][2:0]       ctrlVec;
  logic [NUM_CH-1:0]            rawVec, expVec, maskedVec;

  tick_timer_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .VERSION(VERSION)) u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .loadVec(loadVec), .cntVec(cntVec), .ctrlVec(ctrlVec),
    .rawVec(rawVec), .maskedVec(maskedVec),
    .strobe(strobe), .prdata(prdata)
  );

  tick_timer_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(pclk), .rstn(presetn), .strobe(strobe), .wdata(pwdata),
    .loadVec(loadVec), .cntVec(cntVec), .ctrlVec(ctrlVec),
    .rawVec(rawVec), .expVec(expVec), .maskedVec(maskedVec)
  );

  assign pready  = 1'b1;
  assign chanIrq = maskedVec;
  assign anyIrq  = |maskedVec;
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 32
) (
  input logic                         clk,
  input logic                         rstn,
  input chanStrobe_t [NUM_CH-1:0]     strobe,
  input logic [31:0]                  wdata,
  input logic [NUM_CH-1:0][CNT_W-1:0] loadVec,
  input logic [NUM_CH-1:0][CNT_W-1:0] cntVec,
  input logic [NUM_CH-1:0][2:0]       ctrlVec,
  input logic [NUM_CH-1:0]            rawVec,
  input logic [NUM_CH-1:0]            expVec,
  input logic [NUM_CH-1:0]            chanIrq
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstn)
      strobe[i].wrLoad |=> loadVec[i] == $past(wdata[CNT_W-1:0])) else $error("load capture"); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstn)
      ctrlVec[i][0] && cntVec[i] != '0 && !strobe[i].wrCtrl
        |=> cntVec[i] == CNT_W'($past(cntVec[i]) - 1'b1)) else $error("count step"); // R4
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rstn)
      expVec[i] && ctrlVec[i][1] && !strobe[i].wrCtrl && !strobe[i].wrLoad
        |=> cntVec[i] == $past(loadVec[i])) else $error("periodic reload"); // R5
    AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rstn)
      expVec[i] && !ctrlVec[i][1] && !strobe[i].wrCtrl |=> cntVec[i] == '1) else $error("free reload"); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstn)
      strobe[i].clrIrq && !expVec[i] |=> !rawVec[i]) else $error("clear"); // R7
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstn)
      ctrlVec[i][2] |-> !chanIrq[i]) else $error("mask"); // R9
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstn)
      strobe[i].wrCtrl && !wdata[0] |=> !rawVec[i] && cntVec[i] == $past(cntVec[i])) else $error("stop"); // R10
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstn)
      !ctrlVec[i][0] && !strobe[i].wrCtrl |=> $stable(cntVec[i])) else $error("frozen"); // R10
    AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rstn)
      expVec[i] |=> rawVec[i]) else $error("expiry wins"); // R11
  end
endmodule

bind tick_timer_bank tick_timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(pclk), .rstn(presetn), .strobe(strobe), .wdata(pwdata),
  .loadVec(loadVec), .cntVec(cntVec), .ctrlVec(ctrlVec),
  .rawVec(rawVec), .expVec(expVec), .chanIrq(chanIrq)
);

// File: tb/tick_timer_bank_test.sv
`timescale 1ns/1ps
module tick_timer_bank_test;
  localparam int NCH = 4;
  localparam logic [31:0] VER = 32'h3231_312A;

  logic clk = 1'b0, rstn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, anyIrq;
  logic [NCH-1:0] chanIrq;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  tick_timer_bank #(.NUM_CH(NCH), .CNT_W(32), .VERSION(VER)) uut (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .chanIrq(chanIrq), .anyIrq(anyIrq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check(chanIrq == '0 && anyIrq == 0, "R1 irq low", {27'b0, anyIrq, chanIrq}, 0);
    check(pready == 1, "R2 pready", {31'b0, pready}, 1);
    apbRead(8'h08, v); check(v == 0, "R1 ctrl", v, 0);
    apbRead(8'h04, v); check(v == 0, "R1 count", v, 0);
    apbRead(8'hA8, v); check(v == 0, "R1 raw", v, 0);
    apbRead(8'hAC, v); check(v == VER, "R1 version", v, VER);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    apbWrite(8'h00, 32'd100);
    apbWrite(8'h08, 32'd1);
    apbRead(8'h04, v); check(v == 32'd98, "R4 load then count", v, 98);
    apbRead(8'h08, v); check(v == 32'd1, "R3 ctrl readback", v, 1);
    apbRead(8'h00, v); check(v == 32'd100, "R2 load readback", v, 100);
  endtask

  task automatic testPeriodic();
    logic [31:0] v;
    int c0;
    apbWrite(8'h14, 32'd5);
    apbWrite(8'h1C, 32'd3);
    @(posedge chanIrq[1]); c0 = cyc;
    #1 check(anyIrq == 1, "R12 anyIrq", {31'b0, anyIrq}, 1);
    apbRead(8'h20, v); check(v == 0, "R7 ack reads 0", v, 0);
    check(chanIrq[1] == 0, "R7 ack clears", {31'b0, chanIrq[1]}, 0);
    @(posedge chanIrq[1]);
    check(cyc - c0 == 6, "R5 period load+1", cyc - c0, 6);
    repeat (4) @(negedge clk);
    apbRead(8'h20, v);
    check(chanIrq[1] == 1, "R11 expiry wins", {31'b0, chanIrq[1]}, 1);
    apbRead(8'hA0, v); check(v[1] == 1, "R12 masked vector", v, 32'h2);
  endtask

  task automatic testMask();
    logic [31:0] v;
    apbWrite(8'h3C, 32'd2);
    apbWrite(8'h44, 32'd7);
    repeat (12) @(negedge clk);
    check(chanIrq[3] == 0, "R9 line low", {31'b0, chanIrq[3]}, 0);
    apbRead(8'hA8, v); check(v[3] == 1, "R9 raw set", v, 32'h8);
    apbRead(8'hA0, v); check(v[3] == 0, "R9 masked clear", v, 0);
    apbRead(8'h4C, v); check(v == 0, "R9 status 0", v, 0);
    apbRead(8'h40, v); check(v <= 2, "R9 still counting", v, 2);
    apbRead(8'h44, v); check(v == 7, "R3 mask readback", v, 7);
  endtask

  task automatic testDisable();
    logic [31:0] a, b;
    apbWrite(8'h1C, 32'd0);
    apbRead(8'h18, a);
    repeat (5) @(negedge clk);
    apbRead(8'h18, b); check(a == b, "R10 frozen", b, a);
    apbRead(8'hA8, a); check(a[1] == 0, "R10 pending cleared", a, 0);
    check(chanIrq[1] == 0, "R10 line low", {31'b0, chanIrq[1]}, 0);
    apbWrite(8'h44, 32'd0);
  endtask

  task automatic testFreeRun();
    logic [31:0] v;
    apbWrite(8'h28, 32'd3);
    apbWrite(8'h30, 32'd1);
    @(posedge chanIrq[2]);
    apbRead(8'h2C, v); check(v == 32'hFFFF_FFFE, "R6 all-ones reload", v, 32'hFFFF_FFFE);
  endtask

  task automatic testAck();
    logic [31:0] v;
    repeat (120) @(negedge clk);
    apbRead(8'hA8, v); check(v == 32'h5, "R12 raw vector", v, 32'h5);
    apbRead(8'h0C, v);
    apbRead(8'hA8, v); check(v == 32'h4, "R7 own channel only", v, 32'h4);
    apbRead(8'hA4, v); check(v == 0, "R8 global ack reads 0", v, 0);
    apbRead(8'hA8, v); check(v == 0, "R8 all cleared", v, 0);
    check(anyIrq == 0, "R8 anyIrq low", {31'b0, anyIrq}, 0);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    apbRead(8'h50, v); check(v == 0, "R2 slot beyond NUM_CH", v, 0);
    apbRead(8'h9C, v); check(v == 0, "R2 gap", v, 0);
    apbRead(8'hB0, v); check(v == 0, "R2 above globals", v, 0);
    apbWrite(8'h50, 32'hFFFF_FFFF);
    apbWrite(8'h58, 32'hFFFF_FFFF);
    apbRead(8'h08, v); check(v == 1, "R2 stray write ignored", v, 1);
    apbRead(8'hA8, v); check(v == 0, "R2 stray write no flag", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstn = 1;
    @(negedge clk);
    testReset();
    testEnable();
    testPeriodic();
    testMask();
    testDisable();
    testFreeRun();
    testAck();
    testUnmapped();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule